// File: doc/BRIEF.md
# Virtual Cache Bank and Partition Translator

This block turns a last-level cache access into the single cache bank and partition that holds the line. Every request carries two inputs. The first is a virtual-cache identifier, which arrives from the TLB. The second is the line address of a private-cache miss. A small fully associative table of descriptors is matched on the identifier. Each descriptor owns a power-of-two array of bucket targets. A folded XOR of the line address picks one bucket, which spreads one virtual cache's lines over the banks that make it up. Each line therefore has exactly one home, and one lookup finds it without searching several banks.

When the design is built with the two-level option, each bucket also holds a second bank and partition. This second pair is the target for the next level of a virtual hierarchy. A configuration port writes three things: descriptor identifiers and valid bits, bucket contents, and a fallback bank and partition. The fallback pair is returned, with a miss flag, when no descriptor matches. Lookups are accepted every cycle, and each result appears one cycle after its request.

Top module: `vcache_xlate`

## Requirements
- R1: A synchronous active-high reset clears every descriptor valid bit, sets the fallback bank and partition to 0 and drives `rsp_valid` low in the cycle after reset is seen.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high, and low otherwise.
- R3: On a hit, `rsp_bank` and `rsp_part` are the pair stored in the selected bucket of the matching descriptor, and `rsp_miss` is 0.
- R4: The bucket index is the XOR of all `IDX_W`-bit slices of the line address, where `IDX_W` = log2(`N_BUCKET`). Slice k covers address bits k*IDX_W and up, and the top slice is zero-padded.
- R5: When no valid descriptor holds the requested identifier, `rsp_miss` is 1 and `rsp_bank`/`rsp_part` equal the fallback pair as it stood in the request cycle.
- R6: When several valid descriptors hold the same identifier, the one with the lowest entry index is used.
- R7: A bucket write (`cfg_op` = 2) is seen by lookups from the next cycle on. A lookup in the same cycle as that write returns the old bucket contents.
- R8: A descriptor write (`cfg_op` = 1) sets that entry's identifier and valid bit for lookups from the next cycle on. A lookup in the same cycle uses the old identifier and valid bit.
- R9: With `TWO_LEVEL` = 1, `rsp_nxt_bank`/`rsp_nxt_part` carry the bucket's second-level pair on a hit and are 0 on a miss.
- R10: In a cycle without `req_valid`, every response field keeps its value. This holds even when configuration writes occur in that cycle. A fallback write is `cfg_op` = 3, and `cfg_op` = 0 is no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe, accepted every cycle |
| req_vcid | input | VCID_W | Virtual-cache identifier from the TLB |
| req_addr | input | ADDR_W | Line address of the private-cache miss |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_miss | output | 1 | No descriptor matched the identifier |
| rsp_bank | output | BANK_W | Target bank |
| rsp_part | output | PART_W | Target partition within the bank |
| rsp_nxt_bank | output | BANK_W | Second-level bank (0 on miss or single-level build) |
| rsp_nxt_part | output | PART_W | Second-level partition |
| cfg_op | input | 2 | 0 none, 1 descriptor, 2 bucket, 3 fallback |
| cfg_entry | input | ENT_W | Descriptor entry written |
| cfg_bucket | input | IDX_W | Bucket index written |
| cfg_vcid | input | VCID_W | Identifier for a descriptor write |
| cfg_en | input | 1 | Valid bit for a descriptor write |
| cfg_bank | input | BANK_W | Bank for a bucket or fallback write |
| cfg_part | input | PART_W | Partition for a bucket or fallback write |
| cfg_nxt_bank | input | BANK_W | Second-level bank for a bucket write |
| cfg_nxt_part | input | PART_W | Second-level partition for a bucket write |

## Verification
A reduced build is swept over every identifier and every line address, one request per cycle. Matching, non-matching and duplicated identifiers are all present, so the sweep tells the slice-fold hash apart from any other bucket choice. It also separates hits from fallback results and the first of two duplicate entries from the second. Directed patterns then set a lookup beside a bucket write and beside a descriptor write in the same cycle, to tell old contents from new. Idle cycles mixed with configuration writes show that the held response does not move.

// File: rtl/vcx_pkg.sv
package vcx_pkg;
  typedef enum logic [1:0] {
    CFG_NONE   = 2'd0,
    CFG_DESC   = 2'd1,
    CFG_BUCKET = 2'd2,
    CFG_FALLBK = 2'd3
  } cfg_op_e;
endpackage

// File: rtl/vcx_fold.sv
module vcx_fold #(
  parameter int ADDR_W = 40,
  parameter int IDX_W  = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);
  localparam int N_SLICE = (ADDR_W + IDX_W - 1) / IDX_W;
  localparam int PAD_W   = N_SLICE * IDX_W;

  logic [PAD_W-1:0] padded;
  logic [IDX_W-1:0] slice [N_SLICE];

  assign padded = PAD_W'(addr);

  for (genvar s = 0; s < N_SLICE; s++) begin : g_slice
    assign slice[s] = padded[s*IDX_W +: IDX_W];
  end

  always_comb begin
    idx = '0;
    for (int s = 0; s < N_SLICE; s++) idx = idx ^ slice[s];
  end
endmodule

// File: rtl/vcx_tag_cam.sv
module vcx_tag_cam #(
  parameter int N_DESC = 4,
  parameter int VCID_W = 12,
  parameter int ENT_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ENT_W-1:0]  wr_entry,
  input  logic [VCID_W-1:0] wr_vcid,
  input  logic              wr_valid,
  input  logic [VCID_W-1:0] look_vcid,
  output logic              hit,
  output logic [ENT_W-1:0]  hit_entry
);
  logic [N_DESC-1:0] vld;
  logic [VCID_W-1:0] id [N_DESC];
  logic [N_DESC-1:0] raw;

  for (genvar e = 0; e < N_DESC; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        vld[e] <= 1'b0;
        id[e]  <= '0;
      end else if (wr_en && wr_entry == ENT_W'(e)) begin
        vld[e] <= wr_valid;
        id[e]  <= wr_vcid;
      end
    end
    assign raw[e] = vld[e] && (id[e] == look_vcid);
  end

  // lowest matching entry wins
  always_comb begin
    hit_entry = '0;
    for (int e = N_DESC - 1; e >= 0; e--) begin
      if (raw[e]) hit_entry = ENT_W'(e);
    end
  end
  assign hit = |raw;

  AST_DESC_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (vld[$past(wr_entry)] == $past(wr_valid)) && (id[$past(wr_entry)] == $past(wr_vcid))); // R8
  AST_HIT_IS_MATCH: assert property (@(posedge clk) disable iff (rst)
    hit |-> (vld[hit_entry] && id[hit_entry] == look_vcid)); // R3
endmodule

// File: rtl/vcx_bucket_ram.sv
module vcx_bucket_ram #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 20,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  // read-first: a same-cycle read sees the old word
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/vcache_xlate.sv
module vcache_xlate
  import vcx_pkg::*;
#(
  parameter int VCID_W    = 12,
  parameter int ADDR_W    = 40,
  parameter int N_DESC    = 4,
  parameter int N_BUCKET  = 64,
  parameter int BANK_W    = 6,
  parameter int PART_W    = 4,
  parameter int TWO_LEVEL = 1,
  localparam int ENT_W    = $clog2(N_DESC),
  localparam int IDX_W    = $clog2(N_BUCKET)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [VCID_W-1:0] req_vcid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_miss,
  output logic [BANK_W-1:0] rsp_bank,
  output logic [PART_W-1:0] rsp_part,
  output logic [BANK_W-1:0] rsp_nxt_bank,
  output logic [PART_W-1:0] rsp_nxt_part,
  input  logic [1:0]        cfg_op,
  input  logic [ENT_W-1:0]  cfg_entry,
  input  logic [IDX_W-1:0]  cfg_bucket,
  input  logic [VCID_W-1:0] cfg_vcid,
  input  logic              cfg_en,
  input  logic [BANK_W-1:0] cfg_bank,
  input  logic [PART_W-1:0] cfg_part,
  input  logic [BANK_W-1:0] cfg_nxt_bank,
  input  logic [PART_W-1:0] cfg_nxt_part
);
  localparam int PAIR_W = BANK_W + PART_W;
  localparam int WORD_W = (TWO_LEVEL != 0) ? 2 * PAIR_W : PAIR_W;
  localparam int DEPTH  = N_DESC * N_BUCKET;
  localparam int RAM_AW = ENT_W + IDX_W;

  cfg_op_e op;
  assign op = cfg_op_e'(cfg_op);

  // lookup front end
  logic [IDX_W-1:0] bkt_idx;
  logic             cam_hit;
  logic [ENT_W-1:0] cam_entry;

  vcx_fold #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_fold (
    .addr (req_addr),
    .idx  (bkt_idx)
  );

  vcx_tag_cam #(.N_DESC(N_DESC), .VCID_W(VCID_W), .ENT_W(ENT_W)) u_cam (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (op == CFG_DESC),
    .wr_entry  (cfg_entry),
    .wr_vcid   (cfg_vcid),
    .wr_valid  (cfg_en),
    .look_vcid (req_vcid),
    .hit       (cam_hit),
    .hit_entry (cam_entry)
  );

  // bucket storage
  logic [WORD_W-1:0] wr_word;
  logic [WORD_W-1:0] rd_word;

  if (TWO_LEVEL != 0) begin : g_two
    assign wr_word = {cfg_nxt_bank, cfg_nxt_part, cfg_bank, cfg_part};
  end else begin : g_one
    assign wr_word = {cfg_bank, cfg_part};
  end

  vcx_bucket_ram #(.DEPTH(DEPTH), .WIDTH(WORD_W), .AW(RAM_AW)) u_ram (
    .clk   (clk),
    .we    (op == CFG_BUCKET),
    .waddr ({cfg_entry, cfg_bucket}),
    .wdata (wr_word),
    .re    (req_valid),
    .raddr ({cam_entry, bkt_idx}),
    .rdata (rd_word)
  );

  // fallback register
  logic [BANK_W-1:0] fb_bank;
  logic [PART_W-1:0] fb_part;

  always_ff @(posedge clk) begin
    if (rst) begin
      fb_bank <= '0;
      fb_part <= '0;
    end else if (op == CFG_FALLBK) begin
      fb_bank <= cfg_bank;
      fb_part <= cfg_part;
    end
  end

  // response stage
  logic              vld_q;
  logic              miss_q;
  logic [BANK_W-1:0] fbb_q;
  logic [PART_W-1:0] fbp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      miss_q <= 1'b1;
      fbb_q  <= '0;
      fbp_q  <= '0;
    end else begin
      vld_q <= req_valid;
      if (req_valid) begin
        miss_q <= !cam_hit;
        fbb_q  <= fb_bank;
        fbp_q  <= fb_part;
      end
    end
  end

  logic [BANK_W-1:0] rd_bank;
  logic [PART_W-1:0] rd_part;
  assign {rd_bank, rd_part} = rd_word[PAIR_W-1:0];

  assign rsp_valid = vld_q;
  assign rsp_miss  = miss_q;
  assign rsp_bank  = miss_q ? fbb_q : rd_bank;
  assign rsp_part  = miss_q ? fbp_q : rd_part;

  if (TWO_LEVEL != 0) begin : g_nxt
    logic [BANK_W-1:0] rd_nb;
    logic [PART_W-1:0] rd_np;
    assign {rd_nb, rd_np} = rd_word[WORD_W-1:PAIR_W];
    assign rsp_nxt_bank = miss_q ? '0 : rd_nb;
    assign rsp_nxt_part = miss_q ? '0 : rd_np;
  end else begin : g_no_nxt
    assign rsp_nxt_bank = '0;
    assign rsp_nxt_part = '0;
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !rsp_valid); // R1
  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R2
  AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid); // R2
  AST_UNMATCHED_MISSES: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !cam_hit) |=> rsp_miss); // R5
  AST_MISS_NO_NEXT: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_miss) |-> (rsp_nxt_bank == '0 && rsp_nxt_part == '0)); // R9
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ($stable(rsp_bank) && $stable(rsp_part) && $stable(rsp_miss)
                    && $stable(rsp_nxt_bank) && $stable(rsp_nxt_part))); // R10
endmodule

// File: tb/test_vcache_xlate.sv
`timescale 1ns/1ps
module test_vcache_xlate;
  localparam int VCID_W = 4;
  localparam int ADDR_W = 10;
  localparam int N_DESC = 4;
  localparam int NB     = 8;
  localparam int BANK_W = 4;
  localparam int PART_W = 3;
  localparam int ENT_W  = 2;
  localparam int IDX_W  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [VCID_W-1:0] req_vcid = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic rsp_valid, rsp_miss;
  logic [BANK_W-1:0] rsp_bank, rsp_nxt_bank;
  logic [PART_W-1:0] rsp_part, rsp_nxt_part;
  logic [1:0] cfg_op = 2'd0;
  logic [ENT_W-1:0] cfg_entry = '0;
  logic [IDX_W-1:0] cfg_bucket = '0;
  logic [VCID_W-1:0] cfg_vcid = '0;
  logic cfg_en = 1'b0;
  logic [BANK_W-1:0] cfg_bank = '0, cfg_nxt_bank = '0;
  logic [PART_W-1:0] cfg_part = '0, cfg_nxt_part = '0;

  always #2.5 clk = ~clk;

  vcache_xlate #(
    .VCID_W(VCID_W), .ADDR_W(ADDR_W), .N_DESC(N_DESC), .N_BUCKET(NB),
    .BANK_W(BANK_W), .PART_W(PART_W), .TWO_LEVEL(1)
  ) i_vcache_xlate (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vcid(req_vcid), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_miss(rsp_miss), .rsp_bank(rsp_bank), .rsp_part(rsp_part),
    .rsp_nxt_bank(rsp_nxt_bank), .rsp_nxt_part(rsp_nxt_part),
    .cfg_op(cfg_op), .cfg_entry(cfg_entry), .cfg_bucket(cfg_bucket), .cfg_vcid(cfg_vcid),
    .cfg_en(cfg_en), .cfg_bank(cfg_bank), .cfg_part(cfg_part),
    .cfg_nxt_bank(cfg_nxt_bank), .cfg_nxt_part(cfg_nxt_part)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model of the configuration
  int m_id [N_DESC];
  bit m_vld [N_DESC];
  int m_b [N_DESC][NB];
  int m_p [N_DESC][NB];
  int m_nb [N_DESC][NB];
  int m_np [N_DESC][NB];
  int m_fb = 0, m_fp = 0;

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int fold(int a);
    int r = 0;
    for (int k = 0; k < ADDR_W; k += IDX_W) r = r ^ ((a >> k) % NB);
    return r;
  endfunction

  task automatic predict(int v, int a, output int miss, output int b, output int p,
                         output int nb, output int np);
    int e = -1;
    for (int i = N_DESC - 1; i >= 0; i--) if (m_vld[i] && m_id[i] == v) e = i;
    if (e < 0) begin
      miss = 1; b = m_fb; p = m_fp; nb = 0; np = 0;
    end else begin
      int h = fold(a);
      miss = 0; b = m_b[e][h]; p = m_p[e][h]; nb = m_nb[e][h]; np = m_np[e][h];
    end
  endtask

  task automatic check_rsp(int miss, int b, int p, int nb, int np, string tag);
    chk({tag, " R2 valid"}, int'(rsp_valid), 1);
    chk({tag, " R5 miss"}, int'(rsp_miss), miss);
    chk({tag, " R3 R4 bank"}, int'(rsp_bank), b);
    chk({tag, " R3 R4 part"}, int'(rsp_part), p);
    chk({tag, " R9 next bank"}, int'(rsp_nxt_bank), nb);
    chk({tag, " R9 next part"}, int'(rsp_nxt_part), np);
  endtask

  // one lookup per cycle; request driven after negedge, result checked at next negedge
  task automatic look(int v, int a, string tag);
    int miss, b, p, nb, np;
    predict(v, a, miss, b, p, nb, np);
    req_valid = 1'b1; req_vcid = VCID_W'(v); req_addr = ADDR_W'(a);
    @(negedge clk);
    check_rsp(miss, b, p, nb, np, tag);
  endtask

  task automatic idle();
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr_desc(int e, int id, bit v);
    cfg_op = 2'd1; cfg_entry = ENT_W'(e); cfg_vcid = VCID_W'(id); cfg_en = v;
    @(negedge clk);
    cfg_op = 2'd0;
    m_id[e] = id; m_vld[e] = v;
  endtask

  task automatic wr_bkt(int e, int h, int b, int p, int nb, int np);
    cfg_op = 2'd2; cfg_entry = ENT_W'(e); cfg_bucket = IDX_W'(h);
    cfg_bank = BANK_W'(b); cfg_part = PART_W'(p);
    cfg_nxt_bank = BANK_W'(nb); cfg_nxt_part = PART_W'(np);
    @(negedge clk);
    cfg_op = 2'd0;
    m_b[e][h] = b; m_p[e][h] = p; m_nb[e][h] = nb; m_np[e][h] = np;
  endtask

  task automatic wr_fb(int b, int p);
    cfg_op = 2'd3; cfg_bank = BANK_W'(b); cfg_part = PART_W'(p);
    @(negedge clk);
    cfg_op = 2'd0;
    m_fb = b; m_fp = p;
  endtask

  initial begin
    for (int e = 0; e < N_DESC; e++) begin
      m_vld[e] = 0; m_id[e] = 0;
      for (int h = 0; h < NB; h++) begin
        m_b[e][h] = 0; m_p[e][h] = 0; m_nb[e][h] = 0; m_np[e][h] = 0;
      end
    end
    repeat (3) @(negedge clk);
    chk("R1 valid low in reset", int'(rsp_valid), 0);
    rst = 1'b0;
    // R1 + R5: nothing valid, fallback is zero
    look(3, 5, "R1 after reset");
    idle();
    chk("R2 valid low when idle", int'(rsp_valid), 0);

    // configure fallback, buckets and descriptors
    wr_fb(9, 5);
    for (int e = 0; e < N_DESC; e++)
      for (int h = 0; h < NB; h++)
        wr_bkt(e, h, (e*5 + h*3 + 1) % 16, (e + h) % 8, (e*7 + h) % 16, (h*3 + e + 2) % 8);
    wr_desc(0, 3, 1'b1);
    wr_desc(1, 7, 1'b1);
    wr_desc(2, 12, 1'b1);
    wr_desc(3, 7, 1'b1); // duplicate id, entry 1 must win (R6)

    // exhaustive sweep, back to back
    for (int v = 0; v < 16; v++)
      for (int a = 0; a < (1 << ADDR_W); a++)
        look(v, a, "sweep");

    // R10: idle cycles with configuration writes leave the response alone
    look(12, 77, "R10 setup");
    begin
      int hb, hp, hm;
      hb = int'(rsp_bank); hp = int'(rsp_part); hm = int'(rsp_miss);
      req_valid = 1'b0;
      wr_bkt(2, fold(77), 2, 1, 3, 4);
      wr_fb(4, 6);
      chk("R10 bank held", int'(rsp_bank), hb);
      chk("R10 part held", int'(rsp_part), hp);
      chk("R10 miss held", int'(rsp_miss), hm);
    end
    look(12, 77, "R7 new bucket visible");
    look(9, 1, "R5 new fallback");

    // R6: drop entry 1, identifier 7 falls to entry 3
    wr_desc(1, 7, 1'b0);
    look(7, 200, "R6 second duplicate");

    // R7: lookup in the same cycle as a bucket write returns old contents
    begin
      int miss, b, p, nb, np;
      int h = fold(300);
      predict(3, 300, miss, b, p, nb, np);
      req_valid = 1'b1; req_vcid = 4'd3; req_addr = 10'd300;
      cfg_op = 2'd2; cfg_entry = 2'd0; cfg_bucket = IDX_W'(h);
      cfg_bank = 4'd15; cfg_part = 3'd7; cfg_nxt_bank = 4'd14; cfg_nxt_part = 3'd6;
      @(negedge clk);
      cfg_op = 2'd0;
      check_rsp(miss, b, p, nb, np, "R7 old contents");
      m_b[0][h] = 15; m_p[0][h] = 7; m_nb[0][h] = 14; m_np[0][h] = 6;
      look(3, 300, "R7 new contents");
    end

    // R8: lookup in the same cycle as a descriptor write uses old id/valid
    begin
      int miss, b, p, nb, np;
      predict(12, 500, miss, b, p, nb, np);
      chk("R8 precondition hit", miss, 0);
      req_valid = 1'b1; req_vcid = 4'd12; req_addr = 10'd500;
      cfg_op = 2'd1; cfg_entry = 2'd2; cfg_vcid = 4'd12; cfg_en = 1'b0;
      @(negedge clk);
      cfg_op = 2'd0;
      check_rsp(miss, b, p, nb, np, "R8 old descriptor");
      m_vld[2] = 0;
      look(12, 500, "R8 invalidated");
      chk("R8 now a miss", int'(rsp_miss), 1);
    end

    // R1: reset again clears descriptors and fallback
    req_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 valid low in second reset", int'(rsp_valid), 0);
    rst = 1'b0;
    for (int e = 0; e < N_DESC; e++) m_vld[e] = 0;
    m_fb = 0; m_fp = 0;
    look(3, 300, "R1 descriptors cleared");
    idle();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule